// File: doc/BRIEF.md
# Power-on reset time-out sequencer

This block keeps a processor core in reset after a power-on event, or holds it again after a wake from a low-power state, until its clocks can be trusted. It chains up to three timed stages in a fixed order. The first is a power-up delay counted on a slow internal RC clock. The second is an oscillator start-up delay counted on the main oscillator clock. The third is a PLL lock delay counted again on the RC clock. The oscillator mode code, an active-low delay enable and the kind of event decide which stages run.

The control state machine lives in the RC clock domain. The oscillator start-up counter lives in the oscillator domain. Requests and completion flags cross between the two through two-flop synchronizers. The external active-low master reset pin is kept apart from the timers. If the pin is still low when the last stage ends, raising it releases the core after the pin's synchronizer delay and nothing else. A stage output reports the active stage so that the order and length of the stages can be observed.

Top module: `por_timeout_seq`

## Requirements
- R1: While `por_i` is high, the sequencer is held in stage IDLE and `core_rst_o` is high. Stage codes are IDLE=0, PWRT=1, OST=2, PLL=3, RUN=4.
- R2: When `pwr_dly_en_n_i` is 0, a power-on sequence starts with stage PWRT. That stage lasts exactly 2**PWRT_W RC clock cycles, which is 2048 by default.
- R3: When `pwr_dly_en_n_i` is 1, stage PWRT never occurs.
- R4: Stage OST occurs only in the crystal modes, codes 0 to 3 (LP, XT, HS, HS with PLL). It follows the power-up delay and lasts at least 2**OST_W oscillator cycles, plus a few cycles of synchronizer latency.
- R5: Stage PLL occurs only in mode code 3. It follows OST and lasts exactly PLL_TICKS RC cycles, which is 63 by default.
- R6: In the RC, external-clock and internal-oscillator modes (codes 4 to 7) with the power-up delay disabled, the sequencer goes from IDLE directly to RUN.
- R7: Within a sequence the stage code never decreases, and each sequence ends in RUN.
- R8: `core_rst_o` falls one RC cycle after the sequencer enters RUN if `mclr_n_i` is high. If the pin is low it stays high. Raising the pin while in RUN drops `core_rst_o` on the third RC edge.
- R9: A one-cycle `wake_i` pulse in RUN in a crystal mode runs OST again, then PLL in mode 3, with no PWRT stage. In the other modes it leaves RUN and `core_rst_o` low untouched.
- R10: A new `por_i` pulse in the middle of a sequence returns the sequencer to IDLE. Afterwards the full sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc_i | input | 1 | Slow internal RC clock; the sequencer runs on it |
| clk_osc_i | input | 1 | Main oscillator clock for the start-up count |
| por_i | input | 1 | Power-on pulse, active-high, synchronous to clk_rc_i |
| mclr_n_i | input | 1 | External master reset pin, active-low, asynchronous |
| wake_i | input | 1 | One-cycle wake-from-low-power event, clk_rc_i domain |
| osc_mode_i | input | 3 | Oscillator mode code (0 LP, 1 XT, 2 HS, 3 HS+PLL, 4 RC, 5 external clock, 6 internal, 7 as RC) |
| pwr_dly_en_n_i | input | 1 | Power-up delay enable, active-low |
| core_rst_o | output | 1 | Core reset, high while the core must be held |
| stage_o | output | 3 | Active stage code |

## Verification
The assertions assume that `osc_mode_i` and `pwr_dly_en_n_i` change only while `por_i` is high. They also assume that `wake_i` is a single RC cycle wide and synchronous to the RC clock. The stimulus loads every new mode and enable value inside the power-on pulse and keeps the values steady until the next pulse. It sends a wake pulse only once RUN has been stable for a dozen RC cycles, which lets the previous start-up handshake drain.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4
  } seq_stage_e;

  localparam logic [2:0] MODE_LP      = 3'd0;
  localparam logic [2:0] MODE_XT      = 3'd1;
  localparam logic [2:0] MODE_HS      = 3'd2;
  localparam logic [2:0] MODE_HS_PLL  = 3'd3;
  localparam logic [2:0] MODE_RC      = 3'd4;
  localparam logic [2:0] MODE_EXT_CLK = 3'd5;
  localparam logic [2:0] MODE_INT_OSC = 3'd6;

  function automatic logic mode_is_xtal(input logic [2:0] m);
    return (m <= MODE_HS_PLL);
  endfunction

  function automatic logic mode_has_pll(input logic [2:0] m);
    return (m == MODE_HS_PLL);
  endfunction

endpackage

// File: rtl/pts_sync.sv
module pts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pts_osc_timer.sv
module pts_osc_timer #(
  parameter int OST_W = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic done_o
);
  localparam logic [OST_W-1:0] LAST = {OST_W{1'b1}};

  logic [OST_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !req_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
#(
  parameter int PWRT_W    = 11,
  parameter int PLL_TICKS = 63
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic [2:0] mode_i,
  input  logic       dly_en_n_i,
  input  logic       wake_i,
  input  logic       ost_done_i,
  input  logic       mclr_ok_i,
  output logic [2:0] stage_o,
  output logic       ost_req_o,
  output logic       core_rst_o
);
  localparam int PLL_CW = $clog2(PLL_TICKS + 1);
  localparam int CNT_W  = (PWRT_W > PLL_CW) ? PWRT_W : PLL_CW;
  localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'((1 << PWRT_W) - 1);
  localparam logic [CNT_W-1:0] PLL_LAST  = CNT_W'(PLL_TICKS - 1);

  seq_stage_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             ost_req_q, rst_q;
  logic             xtal, pll;

  assign xtal = mode_is_xtal(mode_i);
  assign pll  = mode_has_pll(mode_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!dly_en_n_i) st_d = ST_PWRT;
        else if (xtal)   st_d = ST_OST;
        else             st_d = ST_RUN;
      end
      ST_PWRT: if (cnt_q == PWRT_LAST) st_d = xtal ? ST_OST : ST_RUN;
      ST_OST:  if (ost_done_i)         st_d = pll ? ST_PLL : ST_RUN;
      ST_PLL:  if (cnt_q == PLL_LAST)  st_d = ST_RUN;
      ST_RUN:  if (pend_q && xtal && !ost_done_i) st_d = ST_OST;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_d != st_q)                          cnt_d = '0;
    else if (st_q == ST_PWRT || st_q == ST_PLL) cnt_d = cnt_q + 1'b1;
    else                                       cnt_d = cnt_q;
  end

  assign pend_d = (st_q == ST_RUN) && (st_d == ST_RUN) && xtal && (pend_q || wake_i);

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      ost_req_q <= 1'b0;
      rst_q     <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      pend_q    <= pend_d;
      ost_req_q <= (st_d == ST_OST);
      rst_q     <= !((st_q == ST_RUN) && mclr_ok_i);
    end
  end

  assign stage_o    = st_q;
  assign ost_req_o  = ost_req_q;
  assign core_rst_o = rst_q;
endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq #(
  parameter int PWRT_W      = 11,
  parameter int OST_W       = 10,
  parameter int PLL_TICKS   = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_rc_i,
  input  logic       clk_osc_i,
  input  logic       por_i,
  input  logic       mclr_n_i,
  input  logic       wake_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwr_dly_en_n_i,
  output logic       core_rst_o,
  output logic [2:0] stage_o
);
  logic por_osc, ost_req, ost_req_osc, ost_done_osc, ost_done_rc, mclr_ok;

  pts_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk_i(clk_rc_i), .rst_i(1'b0), .d_i(mclr_n_i), .q_o(mclr_ok));

  pts_sync #(.STAGES(SYNC_STAGES)) u_por_osc_sync (
    .clk_i(clk_osc_i), .rst_i(1'b0), .d_i(por_i), .q_o(por_osc));

  pts_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(clk_osc_i), .rst_i(por_osc), .d_i(ost_req), .q_o(ost_req_osc));

  pts_osc_timer #(.OST_W(OST_W)) u_ost (
    .clk_i(clk_osc_i), .rst_i(por_osc), .req_i(ost_req_osc), .done_o(ost_done_osc));

  pts_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk_i(clk_rc_i), .rst_i(por_i), .d_i(ost_done_osc), .q_o(ost_done_rc));

  pts_ctrl #(.PWRT_W(PWRT_W), .PLL_TICKS(PLL_TICKS)) u_ctrl (
    .clk_i(clk_rc_i), .por_i(por_i), .mode_i(osc_mode_i),
    .dly_en_n_i(pwr_dly_en_n_i), .wake_i(wake_i), .ost_done_i(ost_done_rc),
    .mclr_ok_i(mclr_ok), .stage_o(stage_o), .ost_req_o(ost_req),
    .core_rst_o(core_rst_o));
endmodule

// File: rtl/pts_chk.sv
module pts_chk (
  input logic       clk_rc_i,
  input logic       por_i,
  input logic [2:0] osc_mode_i,
  input logic       pwr_dly_en_n_i,
  input logic       core_rst_o,
  input logic [2:0] stage_o
);
  // R1
  legal_stage_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    stage_o <= 3'd4);

  // R3
  pwrt_needs_enable_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    (stage_o == 3'd1) |-> !pwr_dly_en_n_i);

  // R4
  ost_xtal_only_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    (stage_o == 3'd2) |-> (osc_mode_i <= 3'd3));

  // R5
  pll_mode_only_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    (stage_o == 3'd3) |-> (osc_mode_i == 3'd3));

  // R7
  pwrt_exit_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    (stage_o == 3'd1) |=> (stage_o == 3'd1 || stage_o == 3'd2 || stage_o == 3'd4));

  // R7
  pll_exit_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    (stage_o == 3'd3) |=> (stage_o == 3'd3 || stage_o == 3'd4));

  // R8
  release_after_run_chk: assert property (@(posedge clk_rc_i) disable iff (por_i)
    !core_rst_o |-> ($past(stage_o) == 3'd4));

  // R10
  por_restart_chk: assert property (@(posedge clk_rc_i)
    por_i |=> (stage_o == 3'd0 && core_rst_o));
endmodule

bind por_timeout_seq pts_chk u_pts_chk (
  .clk_rc_i(clk_rc_i), .por_i(por_i), .osc_mode_i(osc_mode_i),
  .pwr_dly_en_n_i(pwr_dly_en_n_i), .core_rst_o(core_rst_o), .stage_o(stage_o));

// File: tb/por_timeout_seq_tb_top.sv
module por_timeout_seq_tb_top;
  localparam int PW = 5, OW = 4, PLLT = 5;
  localparam int TOSC = 10, TRC = 74;
  localparam int PT = 1 << PW, OC = 1 << OW;

  logic clk_osc = 1'b0, clk_rc = 1'b0;
  logic por = 1'b1, mclr_n = 1'b1, wake = 1'b0, en_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic core_rst;
  logic [2:0] stage;
  int checks = 0, errors = 0;
  int n [5];
  bit mono;

  always #(TOSC/2) clk_osc = ~clk_osc;
  always #(TRC/2)  clk_rc  = ~clk_rc;

  por_timeout_seq #(.PWRT_W(PW), .OST_W(OW), .PLL_TICKS(PLLT)) dut_i (
    .clk_rc_i(clk_rc), .clk_osc_i(clk_osc), .por_i(por), .mclr_n_i(mclr_n),
    .wake_i(wake), .osc_mode_i(mode), .pwr_dly_en_n_i(en_n),
    .core_rst_o(core_rst), .stage_o(stage));

  function automatic bit is_xtal(input logic [2:0] m); return m <= 3'd3; endfunction
  function automatic bit is_pll(input logic [2:0] m); return m == 3'd3; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_rc); endtask

  task automatic do_por(input logic [2:0] m, input logic e);
    tick();
    mode = m; en_n = e; por = 1'b1;
    repeat (3) tick();
    chk(stage == 3'd0, "R1 stage", int'(stage), 0);
    chk(core_rst == 1'b1, "R1 core_rst", int'(core_rst), 1);
    por = 1'b0;
  endtask

  task automatic measure();
    int prev = 0;
    n = '{default: 0};
    mono = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (int'(stage) < prev) mono = 1'b0;
      prev = int'(stage);
      if (stage == 3'd4) break;
      n[stage]++;
    end
  endtask

  task automatic check_seq(input logic [2:0] m, input logic e, input bit woke);
    int lo = OC * TOSC / TRC;
    int hi = (OC + 4) * TOSC / TRC + 5;
    chk(mono, "R7 order", int'(mono), 1);
    chk(stage == 3'd4, "R7 ends in RUN", int'(stage), 4);
    if (woke || e) chk(n[1] == 0, woke ? "R9 no PWRT" : "R3", n[1], 0);
    else           chk(n[1] == PT, "R2 PWRT length", n[1], PT);
    if (is_xtal(m)) chk(n[2] >= lo && n[2] <= hi, "R4 OST length", n[2], lo);
    else            chk(n[2] == 0, "R4 no OST", n[2], 0);
    chk(n[3] == (is_pll(m) ? PLLT : 0), "R5 PLL length", n[3], is_pll(m) ? PLLT : 0);
    if (e && !is_xtal(m) && !woke)
      chk(n[1] + n[2] + n[3] == 0, "R6 direct", n[1] + n[2] + n[3], 0);
  endtask

  task automatic full_run(input logic [2:0] m, input logic e, input bit try_wake);
    do_por(m, e);
    measure();
    check_seq(m, e, 1'b0);
    tick();
    chk(core_rst == 1'b0, "R8 release", int'(core_rst), 0);
    if (try_wake) begin
      repeat (12) tick();
      wake = 1'b1;
      tick();
      wake = 1'b0;
      if (is_xtal(m)) begin
        measure();
        check_seq(m, e, 1'b1);
        chk(n[2] > 0, "R9 OST rerun", n[2], 1);
      end else begin
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
          tick();
          if (stage != 3'd4 || core_rst) bad++;
        end
        chk(bad == 0, "R9 wake ignored", bad, 0);
      end
    end
  endtask

  initial begin
    #(TOSC * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) tick();
    chk(stage == 3'd0 && core_rst, "R1 reset state", int'(stage), 0);

    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        full_run(3'(m), e[0], 1'b1);

    for (int i = 0; i < 12; i++)
      full_run(3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));

    // R10: POR in the middle of the power-up delay
    do_por(3'd3, 1'b0);
    repeat (10) tick();
    chk(stage == 3'd1, "R10 in PWRT", int'(stage), 1);
    por = 1'b1;
    tick();
    chk(stage == 3'd0 && core_rst, "R10 back to IDLE", int'(stage), 0);
    por = 1'b0;
    measure();
    check_seq(3'd3, 1'b0, 1'b0);

    // R8: master reset pin held low across the whole sequence
    tick();
    mclr_n = 1'b0;
    do_por(3'd2, 1'b1);
    measure();
    check_seq(3'd2, 1'b1, 1'b0);
    repeat (5) tick();
    chk(core_rst == 1'b1, "R8 held by pin", int'(core_rst), 1);
    mclr_n = 1'b1;
    tick(); tick();
    chk(core_rst == 1'b1, "R8 sync delay", int'(core_rst), 1);
    tick();
    chk(core_rst == 1'b0, "R8 pin release", int'(core_rst), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule